// File: doc/BRIEF.md
# Four-Stage Pipelined Floating-Point Adder

This block adds or subtracts two floating-point operands in a four-stage pipeline. Each operand is a sign bit, a biased exponent and a fractional mantissa whose binary point sits left of its most significant bit. A normalized mantissa therefore reads 0.1xxx in binary, and an all-zero mantissa stands for zero. A new operand pair, with its add/subtract select, may enter on every clock. The result leaves exactly four clocks later, normalized, with a matching valid flag.

The stages, in order, are:
- **Compare:** rank the two exponents and form their difference.
- **Align:** keep the larger exponent and shift the other mantissa right.
- **Add/subtract:** combine the aligned mantissas, using a magnitude compare to pick the sign.
- **Normalize:** shift right once on a carry, or left past leading zeros, and adjust the exponent by the same amount.

All bits shifted out are dropped, so rounding is truncation. The block does not model special values such as infinities or NaNs. It does not detect exponent overflow or underflow, so the caller keeps exponents away from the ends of their range.

Top module: `fpadd_pipe4`

## Requirements
- R1: Every cycle with `in_valid` high produces exactly one cycle with `out_valid` high, exactly 4 clocks later. A new pair is accepted on every clock.
- R2: While `rst` is high, at the clock edge, all stage valid flags clear, including those of operands in flight. `out_valid` is 0 on the cycle after.
- R3: With equal effective signs, the result magnitude is the larger-exponent mantissa plus the other mantissa shifted right by the exponent difference, with the shifted-out bits dropped. The result exponent is the larger exponent.
- R4: `in_sub` = 1 inverts the sign of operand B. With unlike effective signs, the smaller magnitude is subtracted from the larger, and the result takes the sign of the larger aligned magnitude.
- R5: If the mantissa sum reaches 1.0 or more (a carry into bit 16), the result mantissa is the sum shifted right by one, with its low bit dropped, and the exponent is the larger exponent plus 1.
- R6: If the combined mantissa has leading zeros, it is shifted left until bit 15 is 1, and the exponent is reduced by the number of positions shifted.
- R7: An exponent difference of 16 or more turns the smaller-exponent operand into zero before the add.
- R8: A zero combined mantissa gives `out_mant` = 0, `out_exp` = 0 and `out_sign` = 0.
- R9: Each valid result has bit 15 of `out_mant` set, unless `out_mant` is zero.
- R10: With equal exponents, operand A is taken as the larger-exponent operand, and neither mantissa is shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair present this cycle |
| in_sub | input | 1 | 1 = A minus B, 0 = A plus B |
| in_a_sign | input | 1 | Sign of A, 1 = negative |
| in_a_exp | input | 8 | Biased exponent of A |
| in_a_mant | input | 16 | Fractional mantissa of A, bit 15 weighs 1/2 |
| in_b_sign | input | 1 | Sign of B |
| in_b_exp | input | 8 | Biased exponent of B |
| in_b_mant | input | 16 | Fractional mantissa of B |
| out_valid | output | 1 | Result present this cycle |
| out_sign | output | 1 | Result sign |
| out_exp | output | 8 | Result exponent |
| out_mant | output | 16 | Normalized result mantissa |

## Verification
The sweep walks the exponent difference from -19 to +19 over all eight combinations of the two signs and the subtract select. It uses six mantissa pairs chosen to separate behaviours:
- Equal minimum mantissas and all-ones mantissas force a carry renormalization.
- Nearly equal mantissas under subtraction force deep left shifts.
- A zero operand checks that zero is handled like any other operand.
- Differences beyond 15 separate the discard of the smaller operand from plain alignment.

Directed vectors cover exact cancellation to zero, a one-bit difference that needs a 15-place left shift, and a decimal-style carry case. Bubbles in the input stream, and a reset while operands are in flight, show that valid tracks data one for one.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;

    localparam int FPADD_LATENCY = 4;

    // How stage 3 combines the aligned magnitudes
    typedef enum logic [1:0] {
        MAG_SAME_SIGN  = 2'd0,
        MAG_BIG_WINS   = 2'd1,
        MAG_SMALL_WINS = 2'd2
    } mag_case_e;

endpackage

// File: rtl/fpadd_cmp_stage.sv
module fpadd_cmp_stage #(
    parameter int MANT_W = 16,
    parameter int EXP_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_sub,
    input  logic              a_sign,
    input  logic [EXP_W-1:0]  a_exp,
    input  logic [MANT_W-1:0] a_mant,
    input  logic              b_sign,
    input  logic [EXP_W-1:0]  b_exp,
    input  logic [MANT_W-1:0] b_mant,
    output logic              s1_valid,
    output logic              s1_big_sign,
    output logic [EXP_W-1:0]  s1_big_exp,
    output logic [MANT_W-1:0] s1_big_mant,
    output logic              s1_sml_sign,
    output logic [MANT_W-1:0] s1_sml_mant,
    output logic [EXP_W-1:0]  s1_diff
);

    logic              b_eff_sign;
    logic              swap;
    logic [EXP_W-1:0]  diff_d;

    always_comb begin
        b_eff_sign = b_sign ^ in_sub;
        swap       = (b_exp > a_exp);
        diff_d     = swap ? (b_exp - a_exp) : (a_exp - b_exp);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
        end else begin
            s1_valid <= in_valid;
        end
    end

    always_ff @(posedge clk) begin
        s1_big_sign <= swap ? b_eff_sign : a_sign;
        s1_big_exp  <= swap ? b_exp      : a_exp;
        s1_big_mant <= swap ? b_mant     : a_mant;
        s1_sml_sign <= swap ? a_sign     : b_eff_sign;
        s1_sml_mant <= swap ? a_mant     : b_mant;
        s1_diff     <= diff_d;
    end

endmodule

// File: rtl/fpadd_align_stage.sv
module fpadd_align_stage #(
    parameter int MANT_W = 16,
    parameter int EXP_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              s1_valid,
    input  logic              s1_big_sign,
    input  logic [EXP_W-1:0]  s1_big_exp,
    input  logic [MANT_W-1:0] s1_big_mant,
    input  logic              s1_sml_sign,
    input  logic [MANT_W-1:0] s1_sml_mant,
    input  logic [EXP_W-1:0]  s1_diff,
    output logic              s2_valid,
    output logic              s2_big_sign,
    output logic [EXP_W-1:0]  s2_exp,
    output logic [MANT_W-1:0] s2_big_mant,
    output logic              s2_sml_sign,
    output logic [MANT_W-1:0] s2_sml_mant
);

    localparam logic [EXP_W-1:0] SHIFT_LIMIT = EXP_W'(MANT_W);

    logic [MANT_W-1:0] aligned;

    always_comb begin
        if (s1_diff >= SHIFT_LIMIT) begin
            aligned = '0;
        end else begin
            aligned = s1_sml_mant >> s1_diff;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_valid <= 1'b0;
        end else begin
            s2_valid <= s1_valid;
        end
    end

    always_ff @(posedge clk) begin
        s2_big_sign <= s1_big_sign;
        s2_exp      <= s1_big_exp;
        s2_big_mant <= s1_big_mant;
        s2_sml_sign <= s1_sml_sign;
        s2_sml_mant <= aligned;
    end

endmodule

// File: rtl/fpadd_addsub_stage.sv
module fpadd_addsub_stage
    import fpadd_pkg::*;
#(
    parameter int MANT_W = 16,
    parameter int EXP_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              s2_valid,
    input  logic              s2_big_sign,
    input  logic [EXP_W-1:0]  s2_exp,
    input  logic [MANT_W-1:0] s2_big_mant,
    input  logic              s2_sml_sign,
    input  logic [MANT_W-1:0] s2_sml_mant,
    output logic              s3_valid,
    output logic              s3_sign,
    output logic [EXP_W-1:0]  s3_exp,
    output logic [MANT_W:0]   s3_sum
);

    mag_case_e       mcase;
    logic [MANT_W:0] sum_d;
    logic            sign_d;

    always_comb begin
        if (s2_big_sign == s2_sml_sign) begin
            mcase = MAG_SAME_SIGN;
        end else if (s2_big_mant >= s2_sml_mant) begin
            mcase = MAG_BIG_WINS;
        end else begin
            mcase = MAG_SMALL_WINS;
        end
    end

    always_comb begin
        unique case (mcase)
            MAG_SAME_SIGN: begin
                sum_d  = {1'b0, s2_big_mant} + {1'b0, s2_sml_mant};
                sign_d = s2_big_sign;
            end
            MAG_BIG_WINS: begin
                sum_d  = {1'b0, s2_big_mant - s2_sml_mant};
                sign_d = s2_big_sign;
            end
            MAG_SMALL_WINS: begin
                sum_d  = {1'b0, s2_sml_mant - s2_big_mant};
                sign_d = s2_sml_sign;
            end
            default: begin
                sum_d  = '0;
                sign_d = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s3_valid <= 1'b0;
        end else begin
            s3_valid <= s2_valid;
        end
    end

    always_ff @(posedge clk) begin
        s3_sign <= sign_d;
        s3_exp  <= s2_exp;
        s3_sum  <= sum_d;
    end

endmodule

// File: rtl/fpadd_norm_stage.sv
module fpadd_norm_stage #(
    parameter int MANT_W = 16,
    parameter int EXP_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              s3_valid,
    input  logic              s3_sign,
    input  logic [EXP_W-1:0]  s3_exp,
    input  logic [MANT_W:0]   s3_sum,
    output logic              s4_valid,
    output logic              s4_sign,
    output logic [EXP_W-1:0]  s4_exp,
    output logic [MANT_W-1:0] s4_mant
);

    localparam int LZ_W = $clog2(MANT_W + 1);

    logic [LZ_W-1:0]   lead_zeros;
    logic              seen_one;
    logic              carry;
    logic              is_zero;
    logic              sign_d;
    logic [EXP_W-1:0]  exp_d;
    logic [MANT_W-1:0] mant_d;

    // Leading-zero count over the fraction bits
    always_comb begin
        lead_zeros = '0;
        seen_one   = 1'b0;
        for (int i = MANT_W - 1; i >= 0; i--) begin
            if (!seen_one) begin
                if (s3_sum[i]) begin
                    seen_one = 1'b1;
                end else begin
                    lead_zeros = lead_zeros + 1'b1;
                end
            end
        end
    end

    always_comb begin
        carry   = s3_sum[MANT_W];
        is_zero = (s3_sum == '0);
        if (carry) begin
            mant_d = s3_sum[MANT_W:1];
            exp_d  = s3_exp + 1'b1;
            sign_d = s3_sign;
        end else if (is_zero) begin
            mant_d = '0;
            exp_d  = '0;
            sign_d = 1'b0;
        end else begin
            mant_d = s3_sum[MANT_W-1:0] << lead_zeros;
            exp_d  = s3_exp - EXP_W'(lead_zeros);
            sign_d = s3_sign;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s4_valid <= 1'b0;
        end else begin
            s4_valid <= s3_valid;
        end
    end

    always_ff @(posedge clk) begin
        s4_sign <= sign_d;
        s4_exp  <= exp_d;
        s4_mant <= mant_d;
    end

endmodule

// File: rtl/fpadd_pipe4.sv
module fpadd_pipe4 #(
    parameter int MANT_W = 16,
    parameter int EXP_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_sub,
    input  logic              in_a_sign,
    input  logic [EXP_W-1:0]  in_a_exp,
    input  logic [MANT_W-1:0] in_a_mant,
    input  logic              in_b_sign,
    input  logic [EXP_W-1:0]  in_b_exp,
    input  logic [MANT_W-1:0] in_b_mant,
    output logic              out_valid,
    output logic              out_sign,
    output logic [EXP_W-1:0]  out_exp,
    output logic [MANT_W-1:0] out_mant
);

    logic              s1_valid, s1_big_sign, s1_sml_sign;
    logic [EXP_W-1:0]  s1_big_exp, s1_diff;
    logic [MANT_W-1:0] s1_big_mant, s1_sml_mant;

    logic              s2_valid, s2_big_sign, s2_sml_sign;
    logic [EXP_W-1:0]  s2_exp;
    logic [MANT_W-1:0] s2_big_mant, s2_sml_mant;

    logic              s3_valid, s3_sign;
    logic [EXP_W-1:0]  s3_exp;
    logic [MANT_W:0]   s3_sum;

    fpadd_cmp_stage #(.MANT_W(MANT_W), .EXP_W(EXP_W)) cmp_i (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_sub     (in_sub),
        .a_sign     (in_a_sign),
        .a_exp      (in_a_exp),
        .a_mant     (in_a_mant),
        .b_sign     (in_b_sign),
        .b_exp      (in_b_exp),
        .b_mant     (in_b_mant),
        .s1_valid   (s1_valid),
        .s1_big_sign(s1_big_sign),
        .s1_big_exp (s1_big_exp),
        .s1_big_mant(s1_big_mant),
        .s1_sml_sign(s1_sml_sign),
        .s1_sml_mant(s1_sml_mant),
        .s1_diff    (s1_diff)
    );

    fpadd_align_stage #(.MANT_W(MANT_W), .EXP_W(EXP_W)) align_i (
        .clk        (clk),
        .rst        (rst),
        .s1_valid   (s1_valid),
        .s1_big_sign(s1_big_sign),
        .s1_big_exp (s1_big_exp),
        .s1_big_mant(s1_big_mant),
        .s1_sml_sign(s1_sml_sign),
        .s1_sml_mant(s1_sml_mant),
        .s1_diff    (s1_diff),
        .s2_valid   (s2_valid),
        .s2_big_sign(s2_big_sign),
        .s2_exp     (s2_exp),
        .s2_big_mant(s2_big_mant),
        .s2_sml_sign(s2_sml_sign),
        .s2_sml_mant(s2_sml_mant)
    );

    fpadd_addsub_stage #(.MANT_W(MANT_W), .EXP_W(EXP_W)) addsub_i (
        .clk        (clk),
        .rst        (rst),
        .s2_valid   (s2_valid),
        .s2_big_sign(s2_big_sign),
        .s2_exp     (s2_exp),
        .s2_big_mant(s2_big_mant),
        .s2_sml_sign(s2_sml_sign),
        .s2_sml_mant(s2_sml_mant),
        .s3_valid   (s3_valid),
        .s3_sign    (s3_sign),
        .s3_exp     (s3_exp),
        .s3_sum     (s3_sum)
    );

    fpadd_norm_stage #(.MANT_W(MANT_W), .EXP_W(EXP_W)) norm_i (
        .clk     (clk),
        .rst     (rst),
        .s3_valid(s3_valid),
        .s3_sign (s3_sign),
        .s3_exp  (s3_exp),
        .s3_sum  (s3_sum),
        .s4_valid(out_valid),
        .s4_sign (out_sign),
        .s4_exp  (out_exp),
        .s4_mant (out_mant)
    );

endmodule

// File: rtl/fpadd_pipe4_chk.sv
module fpadd_pipe4_chk
    import fpadd_pkg::*;
#(
    parameter int MANT_W = 16,
    parameter int EXP_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              out_valid,
    input logic              out_sign,
    input logic [EXP_W-1:0]  out_exp,
    input logic [MANT_W-1:0] out_mant
);

    logic [FPADD_LATENCY-1:0] vld_hist;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_hist <= '0;
        end else begin
            vld_hist <= {vld_hist[FPADD_LATENCY-2:0], in_valid};
        end
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        out_valid == vld_hist[FPADD_LATENCY-1]); // R1

    AST_RESET_FLUSH: assert property (@(posedge clk)
        rst |=> !out_valid); // R2

    AST_ZERO_CANON: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_mant == '0) |-> (out_exp == '0 && !out_sign)); // R8

    AST_MSB_NORMALIZED: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_mant != '0) |-> out_mant[MANT_W-1]); // R9

endmodule

bind fpadd_pipe4 fpadd_pipe4_chk #(.MANT_W(MANT_W), .EXP_W(EXP_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .out_valid(out_valid),
    .out_sign (out_sign),
    .out_exp  (out_exp),
    .out_mant (out_mant)
);

// File: tb/fpadd_pipe4_tb_top.sv
module fpadd_pipe4_tb_top;

    localparam int MW = 16;
    localparam int EW = 8;
    localparam int QD = 4096;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_sub = 1'b0;
    logic          in_a_sign = 1'b0;
    logic [EW-1:0] in_a_exp = '0;
    logic [MW-1:0] in_a_mant = '0;
    logic          in_b_sign = 1'b0;
    logic [EW-1:0] in_b_exp = '0;
    logic [MW-1:0] in_b_mant = '0;
    logic          out_valid;
    logic          out_sign;
    logic [EW-1:0] out_exp;
    logic [MW-1:0] out_mant;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int wr_idx = 0;
    int rd_idx = 0;
    bit done   = 1'b0;

    logic [24:0] exp_res [QD];
    string       exp_tag [QD];
    int          exp_cyc [QD];

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    fpadd_pipe4 #(.MANT_W(MW), .EXP_W(EW)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_sub   (in_sub),
        .in_a_sign(in_a_sign),
        .in_a_exp (in_a_exp),
        .in_a_mant(in_a_mant),
        .in_b_sign(in_b_sign),
        .in_b_exp (in_b_exp),
        .in_b_mant(in_b_mant),
        .out_valid(out_valid),
        .out_sign (out_sign),
        .out_exp  (out_exp),
        .out_mant (out_mant)
    );

    // Arithmetic reference on signed integers
    function automatic void model(input int sa, input int ea, input int ma,
                                  input int sb, input int eb, input int mb,
                                  input int sub, output logic [24:0] res,
                                  output string tag);
        int     d, e, sbe;
        longint va, vb, r, mag;
        bit     moved;
        sbe = sb ^ sub;
        if (eb > ea) begin
            d = eb - ea; e = eb; vb = mb; va = (d >= MW) ? 0 : (ma >> d);
        end else begin
            d = ea - eb; e = ea; va = ma; vb = (d >= MW) ? 0 : (mb >> d);
        end
        if (sa != 0) va = -va;
        if (sbe != 0) vb = -vb;
        r = va + vb;
        mag = (r < 0) ? -r : r;
        if (d == 0) tag = "R10"; else tag = "R3";
        if (sa != sbe) tag = "R4";
        if (d >= MW) tag = "R7";
        if (mag == 0) begin
            res = '0;
            tag = "R8";
            return;
        end
        moved = 1'b0;
        if (mag >= 65536) begin
            mag = mag >> 1;
            e = e + 1;
            tag = "R5";
        end else begin
            while (mag < 32768) begin
                mag = mag << 1;
                e = e - 1;
                moved = 1'b1;
            end
            if (moved) tag = "R6";
        end
        res = {(r < 0) ? 1'b1 : 1'b0, e[7:0], mag[15:0]};
    endfunction

    task automatic send(input int sa, input int ea, input int ma,
                        input int sb, input int eb, input int mb, input int sub);
        logic [24:0] r;
        string       t;
        model(sa, ea, ma, sb, eb, mb, sub, r, t);
        in_valid  = 1'b1;
        in_sub    = sub[0];
        in_a_sign = sa[0];
        in_a_exp  = ea[EW-1:0];
        in_a_mant = ma[MW-1:0];
        in_b_sign = sb[0];
        in_b_exp  = eb[EW-1:0];
        in_b_mant = mb[MW-1:0];
        exp_res[wr_idx % QD] = r;
        exp_tag[wr_idx % QD] = t;
        exp_cyc[wr_idx % QD] = cyc;
        wr_idx++;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    // Output monitor
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            checks++;
            if (rd_idx == wr_idx) begin
                fails++;
                $display("FAIL R1 unexpected output: actual valid=1 expected valid=0");
            end else begin
                if ({out_sign, out_exp, out_mant} !== exp_res[rd_idx % QD]) begin
                    fails++;
                    $display("FAIL %s vec %0d: actual s=%0d e=%0d m=%h expected s=%0d e=%0d m=%h",
                             exp_tag[rd_idx % QD], rd_idx, out_sign, out_exp, out_mant,
                             exp_res[rd_idx % QD][24], exp_res[rd_idx % QD][23:16],
                             exp_res[rd_idx % QD][15:0]);
                end
                checks++;
                if (cyc - exp_cyc[rd_idx % QD] != 4) begin
                    fails++;
                    $display("FAIL R1 latency vec %0d: actual %0d expected 4",
                             rd_idx, cyc - exp_cyc[rd_idx % QD]);
                end
                checks++;
                if (out_mant != 0 && !out_mant[MW-1]) begin
                    fails++;
                    $display("FAIL R9 vec %0d: actual m=%h expected bit15 set", rd_idx, out_mant);
                end
                rd_idx++;
            end
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog: actual hung expected completion");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R2 reset state: actual valid=%0d expected 0", out_valid);
        end
        rst = 1'b0;
        @(negedge clk);

        // Directed: decimal-style carry (0.9504*2^3 + 0.82*2^2)  R5
        send(0, 131, 62285, 0, 130, 53739, 0);
        // Exact cancellation  R8
        send(0, 120, 16'hA5A5, 0, 120, 16'hA5A5, 1);
        // One-LSB difference needs a 15-place left shift  R6
        send(1, 90, 16'h8001, 1, 90, 16'h8000, 1);
        // Far apart: smaller becomes zero  R7
        send(0, 60, 16'h9000, 1, 200, 16'hC000, 0);
        // Equal exponents, no shift  R10
        send(0, 77, 16'h8000, 0, 77, 16'hC000, 1);
        // Both zero
        send(1, 10, 0, 0, 50, 0, 0);
        idle(6);

        // Reset with operands in flight  R2
        send(0, 100, 16'hC000, 0, 100, 16'hC000, 0);
        send(0, 100, 16'h8000, 0, 99, 16'h8000, 0);
        rst = 1'b1;
        in_valid = 1'b0;
        rd_idx = wr_idx;
        @(negedge clk);
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R2 flush: actual valid=%0d expected 0", out_valid);
        end
        rst = 1'b0;
        idle(6);

        // Sweep: exponent difference x signs x subtract x mantissa pairs
        for (int d = -19; d <= 19; d++) begin
            for (int s = 0; s < 8; s++) begin
                for (int p = 0; p < 6; p++) begin
                    int ma, mb;
                    case (p)
                        0: begin ma = 16'h8000; mb = 16'h8000; end
                        1: begin ma = 16'hFFFF; mb = 16'hFFFF; end
                        2: begin ma = 16'hC000; mb = 16'h8001; end
                        3: begin ma = 16'h8001; mb = 16'hFFFE; end
                        4: begin ma = 16'hAAAA; mb = 16'h9555; end
                        default: begin ma = 0; mb = 16'hB00B; end
                    endcase
                    send(s & 1, 100, ma, (s >> 1) & 1, 100 + d, mb, (s >> 2) & 1);
                    if ((p + s) % 7 == 3) idle(1);
                end
            end
        end
        idle(8);

        checks++;
        if (rd_idx != wr_idx) begin
            fails++;
            $display("FAIL R1 output count: actual %0d expected %0d", rd_idx, wr_idx);
        end
        done = 1'b1;
        summary();
    end

endmodule